// File: doc/BRIEF.md
# I2C Slave Address and Status Monitor

This block watches a two-wire bus from the slave side and keeps three per-byte status flags for a receiving target. One flag reports that this device was addressed. A second reports that a broadcast (all-zero) address byte arrived. The third holds the data-line level sampled on the latest clock-line rising edge, which also lets software read back the acknowledge bit of the transfer that just ended.

The raw clock and data lines are synchronised inside the block. START and STOP are derived from them as one-cycle pulses. A separate receive shifter, outside this block, supplies each completed byte together with a one-cycle completion strobe. Software-side strobes for writes and reads of the data register clear the addressed flag.

A format-select input picks between two modes. In address-recognition mode the first byte after a START is compared against the programmed 7-bit own address. In free-data-format mode no comparison is made, and any first byte marks the device as addressed.

Top module: `i2c_slave_stat_mon`

## Requirements
- R1: Reset (synchronous, active high) drives `addressed`, `gcall_seen` and `last_bit` to 0.
- R2: `bus_start` pulses for one cycle when SDA falls while SCL is high. `bus_stop` pulses when SDA rises while SCL is high. An SDA change while SCL is low produces neither pulse.
- R3: With `free_fmt`=0 and `slave_mode`=1, when the first byte after a START completes with `rx_byte[7:1]` equal to `own_addr`, `addressed` is 1 from the clock edge that samples `byte_done`. Bit 0 (read/write) is not compared.
- R4: A first byte whose upper 7 bits differ from `own_addr`, and any byte that is not the first after a START, leave `addressed` at 0 in address-recognition mode.
- R5: A first byte equal to 0x00 after a START, with `slave_mode`=1, sets both `gcall_seen` and `addressed`.
- R6: With `free_fmt`=1 and `slave_mode`=1, the first byte after a START sets `addressed` whatever its value. Later bytes do not set it again.
- R7: A one-cycle `dreg_wr` or `dreg_rd` clears `addressed`. If a set condition occurs in the same cycle, the set wins. `gcall_seen` is unaffected by these strobes.
- R8: A detected START or STOP clears `gcall_seen`, and the clear has priority over a set in the same cycle.
- R9: `gcall_seen` never sets on a zero byte that is not the first after a START. With `slave_mode`=0, neither `gcall_seen` nor `addressed` sets.
- R10: `last_bit` takes the synchronised SDA level at each SCL rising edge and holds it otherwise. After a ninth (acknowledge) clock with SDA low, `last_bit` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| own_addr | input | 7 | Programmed slave address |
| free_fmt | input | 1 | 1 = free-data-format mode, 0 = address recognition |
| slave_mode | input | 1 | 1 when the interface operates as a slave |
| rx_byte | input | 8 | Byte from the external receive shifter |
| byte_done | input | 1 | One-cycle strobe: `rx_byte` is complete |
| dreg_wr | input | 1 | One-cycle strobe: data register written |
| dreg_rd | input | 1 | One-cycle strobe: data register read |
| addressed | output | 1 | Addressed-as-slave flag |
| gcall_seen | output | 1 | General-call flag |
| last_bit | output | 1 | Last SDA level sampled on an SCL rise |
| bus_start | output | 1 | One-cycle START pulse |
| bus_stop | output | 1 | One-cycle STOP pulse |

## Verification
The address comparison is tried with four kinds of first byte:
- an exact match with the read/write bit set, which shows that bit 0 is ignored;
- a value whose upper bits differ by one;
- the all-zero broadcast byte;
- a matching byte sent as the second byte of a transfer, which separates "first byte after START" from "any byte".

Free-data-format mode is then tried with an arbitrary byte, to show that the comparison is bypassed. SDA edges are driven once with SCL high and once with SCL low, which separates real bus conditions from ordinary data changes. Clear strobes are also driven in the same cycle as a set, which exposes the priority between them.

// File: rtl/i2c_mon_pkg.sv
`timescale 1ns/1ps
package i2c_mon_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    // Conditions observed on the synchronised bus lines, valid for one cycle.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic sda_lvl;
    } bus_evt_t;

    // Outcome of judging one completed byte.
    typedef struct packed {
        logic addr_set;
        logic gc_set;
    } byte_verdict_t;

    function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
        return (b == '0);
    endfunction

    function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                        input logic [ADDR_W-1:0] own);
        return (b[BYTE_W-1:1] == own);
    endfunction

endpackage

// File: rtl/i2c_mon_busio.sv
`timescale 1ns/1ps
module i2c_mon_busio
    import i2c_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;
    logic                   sda_now;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_in;
                    sda_q <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
                    sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_now = scl_q[SYNC_STAGES-1];
    assign sda_now = sda_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    always_comb begin
        evt.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        evt.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
        evt.scl_rise = scl_now & ~scl_prev;
        evt.sda_lvl  = sda_now;
    end

endmodule

// File: rtl/i2c_mon_decode.sv
`timescale 1ns/1ps
module i2c_mon_decode
    import i2c_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              free_fmt,
    input  logic              slave_mode,
    output byte_verdict_t     verdict
);

    // Armed by START, consumed by the next completed byte.
    logic first_pend;
    logic first_hit;
    logic gc_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_pend <= 1'b0;
        end else if (start) begin
            first_pend <= 1'b1;
        end else if (byte_done) begin
            first_pend <= 1'b0;
        end
    end

    always_comb begin
        first_hit        = byte_done & first_pend & slave_mode;
        gc_hit           = first_hit & is_gcall(rx_byte);
        verdict.gc_set   = gc_hit;
        verdict.addr_set = first_hit &
                           (free_fmt | gc_hit | addr_match(rx_byte, own_addr));
    end

endmodule

// File: rtl/i2c_mon_flags.sv
`timescale 1ns/1ps
module i2c_mon_flags
    import i2c_mon_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  byte_verdict_t verdict,
    input  logic          dreg_wr,
    input  logic          dreg_rd,
    output logic          addressed,
    output logic          gcall_seen,
    output logic          last_bit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addressed <= 1'b0;
        end else if (verdict.addr_set) begin
            addressed <= 1'b1;
        end else if (dreg_wr | dreg_rd) begin
            addressed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gcall_seen <= 1'b0;
        end else if (evt.start | evt.stop) begin
            gcall_seen <= 1'b0;
        end else if (verdict.gc_set) begin
            gcall_seen <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_bit <= 1'b0;
        end else if (evt.scl_rise) begin
            last_bit <= evt.sda_lvl;
        end
    end

endmodule

// File: rtl/i2c_slave_stat_mon.sv
`timescale 1ns/1ps
module i2c_slave_stat_mon
    import i2c_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              free_fmt,
    input  logic              slave_mode,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              byte_done,
    input  logic              dreg_wr,
    input  logic              dreg_rd,
    output logic              addressed,
    output logic              gcall_seen,
    output logic              last_bit,
    output logic              bus_start,
    output logic              bus_stop
);

    bus_evt_t      evt;
    byte_verdict_t verdict;

    i2c_mon_busio #(.SYNC_STAGES(SYNC_STAGES)) busio_i (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_mon_decode decode_i (
        .clk        (clk),
        .rst        (rst),
        .start      (evt.start),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .own_addr   (own_addr),
        .free_fmt   (free_fmt),
        .slave_mode (slave_mode),
        .verdict    (verdict)
    );

    i2c_mon_flags flags_i (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .verdict    (verdict),
        .dreg_wr    (dreg_wr),
        .dreg_rd    (dreg_rd),
        .addressed  (addressed),
        .gcall_seen (gcall_seen),
        .last_bit   (last_bit)
    );

    assign bus_start = evt.start;
    assign bus_stop  = evt.stop;

endmodule

// File: rtl/i2c_mon_chk.sv
`timescale 1ns/1ps
module i2c_mon_chk (
    input logic       clk,
    input logic       rst,
    input logic       byte_done,
    input logic [7:0] rx_byte,
    input logic       slave_mode,
    input logic       dreg_wr,
    input logic       dreg_rd,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       scl_rise,
    input logic       sda_lvl,
    input logic       addressed,
    input logic       gcall_seen,
    input logic       last_bit
);

    // R3 / R6: the addressed flag only rises on a completed byte in slave mode
    assert_addr_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(addressed) |-> $past(byte_done && slave_mode));

    // R7: the addressed flag only falls after a data-register access
    assert_addr_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(addressed) |-> $past(dreg_wr || dreg_rd));

    // R8: a bus condition leaves the general-call flag low next cycle
    assert_gc_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_start || bus_stop) |=> !gcall_seen);

    // R9: the general-call flag rises only on a zero byte in slave mode
    assert_gc_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(gcall_seen) |-> $past(byte_done && slave_mode && (rx_byte == 8'h00)));

    // R10: last bit follows SDA on a clock rise and holds otherwise
    assert_lrb_capture_R10: assert property (@(posedge clk) disable iff (rst)
        scl_rise |=> (last_bit == $past(sda_lvl)));

    assert_lrb_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(last_bit) |-> $past(scl_rise));

    // R2: START and STOP never coincide
    assert_cond_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_start && bus_stop));

endmodule

bind i2c_slave_stat_mon i2c_mon_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .slave_mode (slave_mode),
    .dreg_wr    (dreg_wr),
    .dreg_rd    (dreg_rd),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .scl_rise   (evt.scl_rise),
    .sda_lvl    (evt.sda_lvl),
    .addressed  (addressed),
    .gcall_seen (gcall_seen),
    .last_bit   (last_bit)
);

// File: tb/i2c_slave_stat_mon_tb.sv
`timescale 1ns/1ps
module i2c_slave_stat_mon_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic       free_fmt = 1'b0;
    logic       slave_mode = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       byte_done = 1'b0;
    logic       dreg_wr = 1'b0;
    logic       dreg_rd = 1'b0;
    logic       addressed;
    logic       gcall_seen;
    logic       last_bit;
    logic       bus_start;
    logic       bus_stop;

    int tests = 0;
    int fails = 0;
    int start_cnt = 0;
    int stop_cnt = 0;

    always #2.5 clk = ~clk;

    i2c_slave_stat_mon dut_i (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .own_addr   (own_addr),
        .free_fmt   (free_fmt),
        .slave_mode (slave_mode),
        .rx_byte    (rx_byte),
        .byte_done  (byte_done),
        .dreg_wr    (dreg_wr),
        .dreg_rd    (dreg_rd),
        .addressed  (addressed),
        .gcall_seen (gcall_seen),
        .last_bit   (last_bit),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop)
    );

    always @(posedge clk) begin
        if (bus_start) start_cnt <= start_cnt + 1;
        if (bus_stop)  stop_cnt  <= stop_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        sda_in = 1'b1; scl_in = 1'b1; tick(4);
        sda_in = 1'b0; tick(4);
        scl_in = 1'b0; tick(4);
    endtask

    task automatic do_stop();
        scl_in = 1'b0; sda_in = 1'b0; tick(4);
        scl_in = 1'b1; tick(4);
        sda_in = 1'b1; tick(4);
    endtask

    task automatic clock_bit(input logic b);
        scl_in = 1'b0; tick(4);
        sda_in = b; tick(4);
        scl_in = 1'b1; tick(4);
        scl_in = 1'b0; tick(4);
    endtask

    task automatic give_byte(input logic [7:0] b);
        rx_byte = b; byte_done = 1'b1; tick(1);
        byte_done = 1'b0;
    endtask

    task automatic clear_all();
        dreg_rd = 1'b1; tick(1); dreg_rd = 1'b0;
        do_stop();
    endtask

    task automatic t_reset();
        check("R1 addressed after reset", addressed, 0);
        check("R1 gcall after reset", gcall_seen, 0);
        check("R1 last_bit after reset", last_bit, 0);
        do_start(); give_byte(8'h00); clock_bit(1'b1);
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
        check("R1 addressed cleared by reset", addressed, 0);
        check("R1 gcall cleared by reset", gcall_seen, 0);
        check("R1 last_bit cleared by reset", last_bit, 0);
        do_stop();
    endtask

    task automatic t_conditions();
        int s0;
        int p0;
        s0 = start_cnt; p0 = stop_cnt;
        do_start();
        check("R2 start pulse count", start_cnt - s0, 1);
        s0 = start_cnt;
        scl_in = 1'b0; sda_in = 1'b1; tick(4); sda_in = 1'b0; tick(4);
        sda_in = 1'b1; tick(4);
        check("R2 no start with SCL low", start_cnt - s0, 0);
        check("R2 no stop with SCL low", stop_cnt - p0, 0);
        do_stop();
        check("R2 stop pulse count", stop_cnt - p0, 1);
    endtask

    task automatic t_addr_match();
        do_start(); give_byte({7'h2A, 1'b1});
        check("R3 match with rw=1 sets addressed", addressed, 1);
        check("R3 match leaves gcall low", gcall_seen, 0);
        dreg_rd = 1'b1; tick(1); dreg_rd = 1'b0;
        check("R7 read clears addressed", addressed, 0);
        give_byte({7'h2A, 1'b0});
        check("R4 second byte match ignored", addressed, 0);
        do_stop();
        do_start(); give_byte({7'h2B, 1'b0});
        check("R4 mismatch leaves addressed low", addressed, 0);
        do_stop();
    endtask

    task automatic t_gcall();
        do_start(); give_byte(8'h00);
        check("R5 general call sets gcall", gcall_seen, 1);
        check("R5 general call sets addressed", addressed, 1);
        dreg_wr = 1'b1; tick(1); dreg_wr = 1'b0;
        check("R7 write clears addressed", addressed, 0);
        check("R7 write keeps gcall", gcall_seen, 1);
        do_start();
        check("R8 start clears gcall", gcall_seen, 0);
        give_byte(8'h00);
        check("R5 general call after repeated start", gcall_seen, 1);
        do_stop();
        check("R8 stop clears gcall", gcall_seen, 0);
        clear_all();
    endtask

    task automatic t_gc_limits();
        do_start(); give_byte({7'h2A, 1'b0});
        dreg_rd = 1'b1; tick(1); dreg_rd = 1'b0;
        give_byte(8'h00);
        check("R9 zero byte not first leaves gcall", gcall_seen, 0);
        check("R4 zero byte not first leaves addressed", addressed, 0);
        do_stop();
        slave_mode = 1'b0;
        do_start(); give_byte(8'h00);
        check("R9 non-slave gcall stays low", gcall_seen, 0);
        check("R9 non-slave addressed stays low", addressed, 0);
        do_stop();
        slave_mode = 1'b1;
    endtask

    task automatic t_free_fmt();
        free_fmt = 1'b1;
        do_start(); give_byte(8'h77);
        check("R6 free format first byte sets addressed", addressed, 1);
        dreg_rd = 1'b1; tick(1); dreg_rd = 1'b0;
        give_byte(8'h54);
        check("R6 free format later byte ignored", addressed, 0);
        do_stop();
        free_fmt = 1'b0;
    endtask

    task automatic t_set_wins();
        do_start();
        rx_byte = {7'h2A, 1'b0}; byte_done = 1'b1; dreg_rd = 1'b1; dreg_wr = 1'b1;
        tick(1);
        byte_done = 1'b0; dreg_rd = 1'b0; dreg_wr = 1'b0;
        check("R7 set wins over clear", addressed, 1);
        clear_all();
    endtask

    task automatic t_last_bit();
        clock_bit(1'b1);
        check("R10 captures high", last_bit, 1);
        sda_in = 1'b0; tick(6);
        check("R10 holds while SCL low", last_bit, 1);
        do_start();
        repeat (8) clock_bit(1'b1);
        clock_bit(1'b0);
        give_byte(8'hFF);
        check("R10 ack bit readback", last_bit, 0);
        do_stop();
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_conditions();
        t_addr_match();
        t_gcall();
        t_gc_limits();
        t_free_fmt();
        t_set_wins();
        t_last_bit();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #500000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule